// File: doc/BRIEF.md
# Threshold Search Sequencing Controller

This controller finds the bias at which a device under test reaches a chosen current. It drives a digital code to an external bias DAC. After each new code it waits a fixed settle interval and then samples a single comparator bit. That bit reports whether the measured device current is at or above a reference level, and the controller supplies that reference level on a separate output. The analog DAC, the current measurement and any conversion to volts or amperes all sit outside the block; everything here is in integer codes.

The block has two search modes. Binary-search mode runs a successive-approximation search toward a fixed target current and reports the code it settles on. Ramp mode starts at code zero and raises the code one count per step. The trip level in this mode is proportional to the device width. The ramp stops at the first code where the comparator trips, or at a hard ceiling code, which sets a limit flag.

The block has no data stream, so every pin is a plain control or status signal with no valid/ready handshake. A search begins with a one-cycle start strobe taken while the block is idle. It ends with a one-cycle done pulse. The result and the limit flag then hold until the next accepted start.

Top module: `thr_search_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_code`, `result`, `cmp_ref`, `done` and `limit_hit` become zero after that edge, and the block is idle.
- R2: A start taken while idle with `mode`=0 (binary search) loads `dac_code` with only its top bit set and `cmp_ref` with SAR_TARGET. With `mode`=1 (ramp) it loads `dac_code` with 0 and `cmp_ref` with `width_um`×NA_PER_UM. Both loads are visible after that edge.
- R3: After each new code, `cmp_hi` is sampled at the (SETTLE_CYC+1)-th following edge, and `dac_code` stays unchanged in between.
- R4: In binary-search mode, each sample keeps the tried bit when `cmp_hi`=0 (current below the reference) and clears it when `cmp_hi`=1. It then tries the next lower bit. Exactly DAC_W samples are taken, so `done` rises DAC_W×(SETTLE_CYC+1) edges after the start edge.
- R5: A binary search ends with `result` and `dac_code` both equal to the final code. With a device that trips at codes ≥ T, the final code is T−1, clamped to the range 0..2^DAC_W−1.
- R6: In ramp mode, `dac_code` never decreases during a search and rises by exactly one per step.
- R7: In ramp mode, the first sample with `cmp_hi`=1 ends the search with `result` equal to the code then in effect and `limit_hit`=0.
- R8: In ramp mode, a sample with `cmp_hi`=0 at code RAMP_MAX ends the search with `result`=RAMP_MAX and `limit_hit`=1. The code never goes above RAMP_MAX.
- R9: A start strobe while a search is running is ignored: the code sequence, `cmp_ref` and the result of that search do not change.
- R10: `done` is high for exactly one cycle per search. `result` and `limit_hit` hold until the next accepted start, which clears `limit_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle strobe that begins a search when idle |
| mode | input | 1 | 0 = binary search, 1 = ramp |
| width_um | input | WID_W | Device width in micrometres, scales the ramp trip level |
| cmp_hi | input | 1 | 1 when the measured current is at or above `cmp_ref` |
| dac_code | output | DAC_W | Bias code to the external DAC |
| cmp_ref | output | REF_W | Reference current level for the comparator, in nA |
| done | output | 1 | One-cycle pulse at the end of a search |
| result | output | DAC_W | Logged code of the last completed search |
| limit_hit | output | 1 | Last ramp reached the ceiling without a trip |

## Verification
Each new code is judged exactly SETTLE_CYC+1 edges after it is applied. A binary search therefore finishes DAC_W×(SETTLE_CYC+1) edges after the start edge, and a ramp that trips at code T finishes (T+1)×(SETTLE_CYC+1) edges after it. The bench measures these latencies from the start edge to the cycle where `done` is first seen. A behavioural reference model advances on the same edges and is compared with every output at each falling edge, so each result is checked in the exact cycle it is due. The modelled device comparator is updated at falling edges from the present code, so `cmp_hi` is always stable when the controller samples it.

// File: rtl/thr_search_pkg.sv
package thr_search_pkg;
  typedef enum logic {
    MODE_SAR  = 1'b0,
    MODE_RAMP = 1'b1
  } srch_mode_e;
endpackage

// File: rtl/thr_settle_timer.sv
module thr_settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic fire
);
  localparam int CW = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  assign fire = run && !restart && (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || restart || fire) cnt_q <= '0;
    else if (run)               cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);
endmodule

// File: rtl/thr_sar_step.sv
module thr_sar_step #(
  parameter int DAC_W = 12,
  parameter int BW    = 4
) (
  input  logic [DAC_W-1:0] cur_code,
  input  logic [BW-1:0]    bit_idx,
  input  logic             cmp_hi,
  output logic [DAC_W-1:0] decided,
  output logic [DAC_W-1:0] next_code,
  output logic             last
);
  logic [DAC_W-1:0] mask;

  for (genvar g = 0; g < DAC_W; g++) begin : g_mask
    assign mask[g] = (bit_idx == BW'(g));
  end

  always_comb begin
    decided   = cmp_hi ? (cur_code & ~mask) : cur_code;
    next_code = decided | (mask >> 1);
    last      = (bit_idx == '0);
  end

  // R4
  sar_onehot_chk: assert final ($onehot0(mask));
endmodule

// File: rtl/thr_ramp_step.sv
module thr_ramp_step #(
  parameter int DAC_W    = 12,
  parameter int RAMP_MAX = 3276
) (
  input  logic [DAC_W-1:0] cur_code,
  output logic [DAC_W-1:0] next_code,
  output logic             at_max
);
  localparam logic [DAC_W-1:0] CEIL = DAC_W'(RAMP_MAX);

  assign at_max    = (cur_code >= CEIL);
  assign next_code = cur_code + 1'b1;
endmodule

// File: rtl/thr_search_ctrl.sv
module thr_search_ctrl
  import thr_search_pkg::*;
#(
  parameter int DAC_W      = 12,
  parameter int WID_W      = 8,
  parameter int REF_W      = 16,
  parameter int SETTLE_CYC = 3,
  parameter int RAMP_MAX   = 3276,
  parameter int NA_PER_UM  = 10,
  parameter int SAR_TARGET = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [WID_W-1:0] width_um,
  input  logic             cmp_hi,
  output logic [DAC_W-1:0] dac_code,
  output logic [REF_W-1:0] cmp_ref,
  output logic             done,
  output logic [DAC_W-1:0] result,
  output logic             limit_hit
);
  localparam int BW = (DAC_W < 2) ? 1 : $clog2(DAC_W);
  localparam logic [DAC_W-1:0] SAR_SEED = DAC_W'(1) << (DAC_W - 1);
  localparam logic [REF_W-1:0] TGT_REF  = REF_W'(SAR_TARGET);
  localparam logic [REF_W-1:0] PER_UM   = REF_W'(NA_PER_UM);

  logic             busy_q, done_q, lim_q;
  srch_mode_e       mode_q;
  logic [DAC_W-1:0] dac_q, res_q;
  logic [BW-1:0]    bit_q;
  logic [REF_W-1:0] ref_q;

  logic             accept, fire;
  logic [DAC_W-1:0] sar_decided, sar_next, ramp_next;
  logic             sar_last, ramp_at_max;

  assign accept = start && !busy_q;

  thr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .run(busy_q), .fire(fire)
  );

  thr_sar_step #(.DAC_W(DAC_W), .BW(BW)) u_sar (
    .cur_code(dac_q), .bit_idx(bit_q), .cmp_hi(cmp_hi),
    .decided(sar_decided), .next_code(sar_next), .last(sar_last)
  );

  thr_ramp_step #(.DAC_W(DAC_W), .RAMP_MAX(RAMP_MAX)) u_ramp (
    .cur_code(dac_q), .next_code(ramp_next), .at_max(ramp_at_max)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      lim_q  <= 1'b0;
      mode_q <= MODE_SAR;
      dac_q  <= '0;
      res_q  <= '0;
      bit_q  <= '0;
      ref_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        lim_q  <= 1'b0;
        mode_q <= srch_mode_e'(mode);
        if (srch_mode_e'(mode) == MODE_SAR) begin
          dac_q <= SAR_SEED;
          bit_q <= BW'(DAC_W - 1);
          ref_q <= TGT_REF;
        end else begin
          dac_q <= '0;
          ref_q <= REF_W'(width_um) * PER_UM;
        end
      end else if (busy_q && fire) begin
        if (mode_q == MODE_SAR) begin
          if (sar_last) begin
            dac_q  <= sar_decided;
            res_q  <= sar_decided;
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            dac_q <= sar_next;
            bit_q <= bit_q - 1'b1;
          end
        end else begin
          if (cmp_hi) begin
            res_q  <= dac_q;
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end else if (ramp_at_max) begin
            res_q  <= dac_q;
            lim_q  <= 1'b1;
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            dac_q <= ramp_next;
          end
        end
      end
    end
  end

  assign dac_code  = dac_q;
  assign cmp_ref   = ref_q;
  assign done      = done_q;
  assign result    = res_q;
  assign limit_hit = lim_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R3
  settle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !fire) |=> $stable(dac_q));

  // R6
  ramp_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && mode_q == MODE_RAMP) |=> (dac_q >= $past(dac_q)));

  // R8
  ramp_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && mode_q == MODE_RAMP) |-> (dac_q <= DAC_W'(RAMP_MAX)));

  // R8
  limit_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lim_q) |-> done_q);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> $stable(ref_q));
endmodule

// File: tb/test_thr_search_ctrl.sv
module test_thr_search_ctrl;
  localparam int DAC_W = 12, WID_W = 8, REF_W = 16;
  localparam int SETTLE_CYC = 3, RAMP_MAX = 3276;
  localparam int NA_PER_UM = 10, SAR_TARGET = 1000;
  localparam int STEP = SETTLE_CYC + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0, cmp_hi = 1'b0;
  logic [WID_W-1:0] width_um = '0;
  logic [DAC_W-1:0] dac_code, result;
  logic [REF_W-1:0] cmp_ref;
  logic done, limit_hit;

  int n_vec = 0, n_bad = 0, thr = 0, wd = 0;
  bit finished = 0;

  // reference model state
  int m_dac = 0, m_res = 0, m_ref = 0, m_cnt = 0, m_bit = 0;
  bit m_done = 0, m_lim = 0, m_busy = 0, m_ramp = 0;

  thr_search_ctrl #(.DAC_W(DAC_W), .WID_W(WID_W), .REF_W(REF_W),
    .SETTLE_CYC(SETTLE_CYC), .RAMP_MAX(RAMP_MAX), .NA_PER_UM(NA_PER_UM),
    .SAR_TARGET(SAR_TARGET)) i_thr_search_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .width_um(width_um),
    .cmp_hi(cmp_hi), .dac_code(dac_code), .cmp_ref(cmp_ref), .done(done),
    .result(result), .limit_hit(limit_hit));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_dac = 0; m_res = 0; m_ref = 0; m_cnt = 0; m_bit = 0;
      m_done = 0; m_lim = 0; m_busy = 0; m_ramp = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_cnt = 0; m_lim = 0; m_ramp = mode;
          if (!mode) begin m_bit = DAC_W - 1; m_dac = 1 << m_bit; m_ref = SAR_TARGET; end
          else begin m_dac = 0; m_ref = width_um * NA_PER_UM; end
        end
      end else if (m_cnt < SETTLE_CYC) m_cnt++;
      else begin
        m_cnt = 0;
        if (!m_ramp) begin
          if (cmp_hi) m_dac = m_dac & ~(1 << m_bit);
          if (m_bit == 0) begin m_res = m_dac; m_done = 1; m_busy = 0; end
          else begin m_bit--; m_dac = m_dac | (1 << m_bit); end
        end else if (cmp_hi) begin m_res = m_dac; m_done = 1; m_busy = 0; end
        else if (m_dac == RAMP_MAX) begin m_res = m_dac; m_lim = 1; m_done = 1; m_busy = 0; end
        else m_dac++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, then refresh the device comparator from the present code
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3", "dac_code", int'(dac_code), m_dac);
      chk("R2", "cmp_ref", int'(cmp_ref), m_ref);
      chk("R10", "done", int'(done), int'(m_done));
      chk("R5", "result", int'(result), m_res);
      chk("R8", "limit_hit", int'(limit_hit), int'(m_lim));
    end
    cmp_hi = (int'(dac_code) >= thr);
    wd++;
    if (wd > 150000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // starts a search; returns edges from the start edge to the first done
  task automatic search(input bit md, input int wid, input int t, output int lat);
    thr = t;
    @(negedge clk);
    mode = md; width_um = WID_W'(wid); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done) begin @(negedge clk); lat++; end
  endtask

  initial begin
    int lat, prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "dac after reset", int'(dac_code), 0);
    chk("R1", "result after reset", int'(result), 0);
    chk("R1", "done/limit after reset", int'(done) + int'(limit_hit), 0);

    // R2 seed codes and references
    thr = 1000;
    @(negedge clk); mode = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "SAR seed code", int'(dac_code), 1 << (DAC_W - 1));
    chk("R2", "SAR reference", int'(cmp_ref), SAR_TARGET);
    lat = 0;
    while (!done) begin @(negedge clk); lat++; end
    chk("R4", "SAR latency", lat, DAC_W * STEP);
    chk("R5", "SAR result thr 1000", int'(result), 999);
    chk("R5", "SAR final dac", int'(dac_code), 999);
    @(negedge clk);
    chk("R10", "done low after pulse", int'(done), 0);
    chk("R10", "result held", int'(result), 999);

    search(1'b0, 0, 0, lat);
    chk("R5", "SAR always tripping", int'(result), 0);
    search(1'b0, 0, 4096, lat);
    chk("R5", "SAR never tripping", int'(result), 4095);
    search(1'b0, 0, 1, lat);
    chk("R4", "SAR thr 1 latency", lat, DAC_W * STEP);
    chk("R5", "SAR thr 1", int'(result), 0);

    // R6 / R7 ramp trip with width-scaled reference
    thr = 37;
    @(negedge clk); mode = 1'b1; width_um = 8'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2", "ramp seed code", int'(dac_code), 0);
    chk("R2", "ramp reference", int'(cmp_ref), 200);
    lat = 0; prev = 0;
    while (!done) begin
      if (int'(dac_code) < prev || int'(dac_code) > prev + 1) chk("R6", "ramp step", int'(dac_code), prev);
      prev = int'(dac_code);
      @(negedge clk); lat++;
    end
    chk("R6", "ramp monotonic final", int'(dac_code), 37);
    chk("R7", "ramp trip latency", lat, 38 * STEP);
    chk("R7", "ramp trip result", int'(result), 37);
    chk("R7", "ramp trip no limit", int'(limit_hit), 0);

    search(1'b1, 5, 0, lat);
    chk("R7", "ramp immediate trip", int'(result), 0);
    chk("R3", "ramp immediate latency", lat, STEP);

    // R8 ceiling
    search(1'b1, 255, 5000, lat);
    chk("R8", "ceiling result", int'(result), RAMP_MAX);
    chk("R8", "ceiling flag", int'(limit_hit), 1);
    chk("R8", "ceiling latency", lat, (RAMP_MAX + 1) * STEP);
    chk("R8", "ceiling reference", int'(cmp_ref), 2550);
    repeat (3) @(negedge clk);
    chk("R10", "limit held", int'(limit_hit), 1);

    // R10 limit cleared by the next accepted start
    thr = 3;
    @(negedge clk); mode = 1'b1; width_um = 8'd1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10", "limit cleared on start", int'(limit_hit), 0);
    while (!done) @(negedge clk);
    chk("R7", "ramp thr 3", int'(result), 3);

    // R9 start while busy is ignored
    thr = 2000;
    @(negedge clk); mode = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 0;
    repeat (10) begin @(negedge clk); lat++; end
    mode = 1'b1; width_um = 8'd7; start = 1'b1;
    @(negedge clk); start = 1'b0; lat++;
    chk("R9", "reference unchanged", int'(cmp_ref), SAR_TARGET);
    while (!done) begin @(negedge clk); lat++; end
    chk("R9", "busy start latency", lat, DAC_W * STEP);
    chk("R9", "busy start result", int'(result), 1999);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule